// File: doc/BRIEF.md
# Die-to-Die Lane Repair Remapper

This block sits between the logical mainband lanes of a die-to-die link module and its physical bump pins. When link bring-up finishes its connection test, it presents a per-pin fault map together with a one-cycle `test_done` strobe. The remapper turns that map into a lane-to-pin configuration and latches it. The configuration then stays fixed until the next reset.

For the advanced-package variant (`ADV=1`), the logical bus is split into `NGRP` repair groups. Each group has one extra spare pin placed above its lanes. The bus may include data, forwarded clock, valid and track signals packed together. A failing pin is bypassed by moving every lane at or above it up one pin, so each lane needs only a 2:1 choice. The receive side applies the mirror-image selection, so logical lane order is preserved. For the standard-package variant (`ADV=0`), which has no spare pins, a fault in one half of the pins selects half-width operation. In that mode each full-width word crosses the healthy half in two beats, low half first. A fault in both halves, or more than one fault in an advanced repair group, leaves the link down and raises a failure flag.

Top module: `lane_repair_remap`

## Requirements
- R1: While and after synchronous reset, `tx_pins`, `rx_lanes`, `rx_valid`, `tx_beat`, `half_width`, `link_up`, `link_fail` and `repair_done` are all 0.
- R2: Advanced pin layout: pin `g*(GW+1)+j` carries lane `g*GW+j` of group `g`, and pin `g*(GW+1)+GW` is the group spare. With no faults, each lane appears on its own pin one cycle after it is driven, and the spare pins stay 0.
- R3: Advanced repair: with one faulty pin at in-group position `p`, lanes of that group with `j >= p` move to pin position `j+1` and the faulty pin is driven 0. A fault on the spare itself changes nothing. Receive lane `j` reads from the same pin that transmit lane `j` uses, one cycle later.
- R4: If any advanced group has two or more faulty pins, `link_fail` rises, `link_up` and `repair_done` stay 0, and `tx_pins`, `rx_lanes` and `rx_valid` stay 0, whatever is driven on `tx_lanes`.
- R5: `repair_done` is a single-cycle pulse, high in the cycle after the edge that samples `test_done`, and `link_up` rises with it. A later `test_done` with a different fault map leaves the mapping unchanged until reset.
- R6: Standard variant with no faults: `half_width` is 0, `tx_pins` equals `tx_lanes` one cycle later, `rx_lanes` equals `rx_pins` one cycle later, and `rx_valid` is 1 on every cycle while the link is up.
- R7: Standard variant with faults in exactly one half (low half = pins `[LW/2-1:0]`): `half_width` is 1. When `tx_beat` is 0, the next edge puts `tx_lanes[LW/2-1:0]` on the healthy half. When `tx_beat` is 1, the next edge puts `tx_lanes[LW-1:LW/2]` there. `tx_beat` alternates every cycle, and the faulty half is driven 0.
- R8: Standard half-width receive: the healthy half sampled while `tx_beat` is 0 becomes the low half of `rx_lanes`. The healthy half sampled while `tx_beat` is 1 becomes the high half. `rx_valid` is 1 only in the cycle that shows the assembled word, and is 0 after the first beat.
- R9: Standard variant with faults in both halves: `link_fail` is 1, and `link_up`, `half_width` and `repair_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_done | input | 1 | Strobe: fault map is valid |
| fault_map | input | PW | Per-pin fault flag from the connection test |
| tx_lanes | input | LW | Logical transmit lanes |
| tx_pins | output | PW | Physical transmit pins (registered) |
| rx_pins | input | PW | Physical receive pins |
| rx_lanes | output | LW | Logical receive lanes (registered) |
| rx_valid | output | 1 | `rx_lanes` holds a valid word |
| tx_beat | output | 1 | Half sent at the next edge in half-width mode (0 low, 1 high) |
| half_width | output | 1 | Degraded half-width operation selected |
| link_up | output | 1 | Mapping applied, link usable |
| link_fail | output | 1 | Fault map could not be repaired |
| repair_done | output | 1 | One-cycle pulse when the mapping becomes valid |

## Verification
The configuration flags and the `repair_done` pulse are due one edge after the edge that samples `test_done`. Every pin or lane result is due one edge after its input is driven. The bench drives on the falling edge and checks on the next falling edge, so each check falls in the cycle where its result is due. In half-width mode, the bench waits for a falling edge where `tx_beat` is 0 before loading a word. It then checks the low beat after one edge and the high beat, with the assembled receive word, after the second edge. A check made after a second `test_done` confirms that the latched mapping has not moved.

// File: rtl/lr_pkg.sv
package lr_pkg;
  typedef enum logic [1:0] {ST_WAIT, ST_UP, ST_FAIL} lr_state_e;
endpackage

// File: rtl/lr_ctrl.sv
module lr_ctrl import lr_pkg::*; #(
  parameter int LW   = 64,
  parameter int NGRP = 4,
  parameter bit ADV  = 1'b1,
  parameter int PW   = LW + NGRP
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          test_done,
  input  logic [PW-1:0] fault_map,
  output logic [LW-1:0] shift_q,
  output logic          half_q,
  output logic          hsel_q,
  output logic          beat_q,
  output logic          link_up,
  output logic          link_fail,
  output logic          done
);
  localparam int GW = LW / NGRP;
  localparam int GP = GW + 1;
  localparam int H  = LW / 2;

  logic [LW-1:0] nshift;
  logic          nhalf, nhsel, nbad;
  lr_state_e     state;

  generate
    if (ADV) begin : g_adv
      always_comb begin
        logic acc;
        nshift = '0;
        nbad   = 1'b0;
        nhalf  = 1'b0;
        nhsel  = 1'b0;
        for (int g = 0; g < NGRP; g++) begin
          acc = 1'b0;
          for (int j = 0; j < GW; j++) begin
            acc = acc | fault_map[g*GP+j];
            nshift[g*GW+j] = acc;
          end
          if ($countones(fault_map[g*GP +: GP]) > 1) nbad = 1'b1;
        end
      end
    end else begin : g_std
      logic lo_bad, hi_bad;
      assign lo_bad = |fault_map[H-1:0];
      assign hi_bad = |fault_map[LW-1:H];
      assign nshift = '0;
      assign nhalf  = lo_bad ^ hi_bad;
      assign nhsel  = lo_bad;
      assign nbad   = lo_bad & hi_bad;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_WAIT;
      shift_q   <= '0;
      half_q    <= 1'b0;
      hsel_q    <= 1'b0;
      beat_q    <= 1'b0;
      link_up   <= 1'b0;
      link_fail <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_WAIT: if (test_done) begin
          if (nbad) begin
            state     <= ST_FAIL;
            link_fail <= 1'b1;
          end else begin
            state   <= ST_UP;
            link_up <= 1'b1;
            done    <= 1'b1;
            shift_q <= nshift;
            half_q  <= nhalf;
            hsel_q  <= nhsel;
          end
        end
        ST_UP: if (half_q) beat_q <= ~beat_q;
        default: ;
      endcase
    end
  end

  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (rst)
    link_up |=> ($stable(shift_q) && $stable(half_q) && $stable(hsel_q))); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R5
  AST_FAIL_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(link_fail && link_up)); // R4
  AST_BEAT_FULL: assert property (@(posedge clk) disable iff (rst)
    !half_q |-> !beat_q); // R7
endmodule

// File: rtl/lr_tx_map.sv
module lr_tx_map #(
  parameter int LW   = 64,
  parameter int NGRP = 4,
  parameter bit ADV  = 1'b1,
  parameter int PW   = LW + NGRP
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          link_up,
  input  logic [LW-1:0] shift_q,
  input  logic          half_q,
  input  logic          hsel_q,
  input  logic          beat_q,
  input  logic [LW-1:0] tx_lanes,
  output logic [PW-1:0] tx_pins
);
  localparam int GW = LW / NGRP;
  localparam int GP = GW + 1;
  localparam int H  = LW / 2;

  logic [PW-1:0] nxt;

  generate
    if (ADV) begin : g_adv
      always_comb begin
        nxt = '0;
        for (int g = 0; g < NGRP; g++)
          for (int j = 0; j < GW; j++)
            if (shift_q[g*GW+j]) nxt[g*GP+j+1] = tx_lanes[g*GW+j];
            else                 nxt[g*GP+j]   = tx_lanes[g*GW+j];
      end
    end else begin : g_std
      logic [H-1:0] piece;
      assign piece = beat_q ? tx_lanes[LW-1:H] : tx_lanes[H-1:0];
      always_comb begin
        nxt = '0;
        if (!half_q)     nxt = tx_lanes;
        else if (hsel_q) nxt[LW-1:H] = piece;
        else             nxt[H-1:0]  = piece;
      end
      AST_DEAD_HALF: assert property (@(posedge clk) disable iff (rst)
        (link_up && half_q && hsel_q) |=> (tx_pins[H-1:0] == '0)); // R7
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !link_up) tx_pins <= '0;
    else                 tx_pins <= nxt;
  end

  AST_TX_QUIET: assert property (@(posedge clk) disable iff (rst)
    !link_up |=> (tx_pins == '0)); // R4
endmodule

// File: rtl/lr_rx_map.sv
module lr_rx_map #(
  parameter int LW   = 64,
  parameter int NGRP = 4,
  parameter bit ADV  = 1'b1,
  parameter int PW   = LW + NGRP
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          link_up,
  input  logic [LW-1:0] shift_q,
  input  logic          half_q,
  input  logic          hsel_q,
  input  logic          beat_q,
  input  logic [PW-1:0] rx_pins,
  output logic [LW-1:0] rx_lanes,
  output logic          rx_valid
);
  localparam int GW = LW / NGRP;
  localparam int GP = GW + 1;
  localparam int H  = LW / 2;

  generate
    if (ADV) begin : g_adv
      logic [LW-1:0] sel;
      always_comb begin
        for (int g = 0; g < NGRP; g++)
          for (int j = 0; j < GW; j++)
            sel[g*GW+j] = shift_q[g*GW+j] ? rx_pins[g*GP+j+1] : rx_pins[g*GP+j];
      end
      always_ff @(posedge clk) begin
        if (rst || !link_up) begin
          rx_lanes <= '0;
          rx_valid <= 1'b0;
        end else begin
          rx_lanes <= sel;
          rx_valid <= 1'b1;
        end
      end
    end else begin : g_std
      logic [H-1:0] piece, low_buf;
      assign piece = hsel_q ? rx_pins[LW-1:H] : rx_pins[H-1:0];
      always_ff @(posedge clk) begin
        if (rst || !link_up) begin
          rx_lanes <= '0;
          rx_valid <= 1'b0;
          low_buf  <= '0;
        end else if (!half_q) begin
          rx_lanes <= rx_pins[LW-1:0];
          rx_valid <= 1'b1;
        end else if (!beat_q) begin
          low_buf  <= piece;
          rx_valid <= 1'b0;
        end else begin
          rx_lanes <= {piece, low_buf};
          rx_valid <= 1'b1;
        end
      end
      AST_RXV_ALT: assert property (@(posedge clk) disable iff (rst)
        (half_q && rx_valid) |=> !rx_valid); // R8
    end
  endgenerate

  AST_RX_QUIET: assert property (@(posedge clk) disable iff (rst)
    !link_up |=> !rx_valid); // R4
endmodule

// File: rtl/lane_repair_remap.sv
module lane_repair_remap #(
  parameter int LW   = 64,
  parameter int NGRP = 4,
  parameter bit ADV  = 1'b1,
  localparam int PW  = ADV ? LW + NGRP : LW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          test_done,
  input  logic [PW-1:0] fault_map,
  input  logic [LW-1:0] tx_lanes,
  output logic [PW-1:0] tx_pins,
  input  logic [PW-1:0] rx_pins,
  output logic [LW-1:0] rx_lanes,
  output logic          rx_valid,
  output logic          tx_beat,
  output logic          half_width,
  output logic          link_up,
  output logic          link_fail,
  output logic          repair_done
);
  logic [LW-1:0] shift_q;
  logic          hsel_q;

  lr_ctrl #(.LW(LW), .NGRP(NGRP), .ADV(ADV), .PW(PW)) u_ctrl (
    .clk(clk), .rst(rst), .test_done(test_done), .fault_map(fault_map),
    .shift_q(shift_q), .half_q(half_width), .hsel_q(hsel_q), .beat_q(tx_beat),
    .link_up(link_up), .link_fail(link_fail), .done(repair_done));

  lr_tx_map #(.LW(LW), .NGRP(NGRP), .ADV(ADV), .PW(PW)) u_tx (
    .clk(clk), .rst(rst), .link_up(link_up), .shift_q(shift_q),
    .half_q(half_width), .hsel_q(hsel_q), .beat_q(tx_beat),
    .tx_lanes(tx_lanes), .tx_pins(tx_pins));

  lr_rx_map #(.LW(LW), .NGRP(NGRP), .ADV(ADV), .PW(PW)) u_rx (
    .clk(clk), .rst(rst), .link_up(link_up), .shift_q(shift_q),
    .half_q(half_width), .hsel_q(hsel_q), .beat_q(tx_beat),
    .rx_pins(rx_pins), .rx_lanes(rx_lanes), .rx_valid(rx_valid));

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    link_fail |=> (link_fail && !repair_done)); // R9
endmodule

// File: tb/tb_lane_repair_remap.sv
module tb_lane_repair_remap;
  localparam int LW = 64, NG = 4, GW = LW / NG, GP = GW + 1, PW = LW + NG;
  localparam int SW = 16, SH = SW / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          a_td = 1'b0;
  logic [PW-1:0] a_fm = '0, a_rxp = '0, a_txp;
  logic [LW-1:0] a_txl = '0, a_rxl;
  logic a_rxv, a_beat, a_half, a_up, a_fail, a_done;

  logic          s_td = 1'b0;
  logic [SW-1:0] s_fm = '0, s_rxp = '0, s_txp, s_txl = '0, s_rxl;
  logic s_rxv, s_beat, s_half, s_up, s_fail, s_done;

  lane_repair_remap #(.LW(LW), .NGRP(NG), .ADV(1'b1)) dut (
    .clk(clk), .rst(rst), .test_done(a_td), .fault_map(a_fm), .tx_lanes(a_txl),
    .tx_pins(a_txp), .rx_pins(a_rxp), .rx_lanes(a_rxl), .rx_valid(a_rxv),
    .tx_beat(a_beat), .half_width(a_half), .link_up(a_up), .link_fail(a_fail),
    .repair_done(a_done));

  lane_repair_remap #(.LW(SW), .NGRP(2), .ADV(1'b0)) dut_std (
    .clk(clk), .rst(rst), .test_done(s_td), .fault_map(s_fm), .tx_lanes(s_txl),
    .tx_pins(s_txp), .rx_pins(s_rxp), .rx_lanes(s_rxl), .rx_valid(s_rxv),
    .tx_beat(s_beat), .half_width(s_half), .link_up(s_up), .link_fail(s_fail),
    .repair_done(s_done));

  int checks = 0, errors = 0;
  int pf[NG];

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int pin_of(input int i);
    int g = i / GW, j = i % GW;
    return g * GP + j + ((j >= pf[g]) ? 1 : 0);
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; a_td = 0; s_td = 0; a_fm = '0; s_fm = '0;
    step(); step();
    rst = 1'b0;
    chk(a_txp == '0 && a_rxl == '0 && !a_rxv && !a_up && !a_fail && !a_done &&
        !a_half && !a_beat, "R1 adv reset", {a_up, a_fail, a_done}, 0);
    chk(s_txp == '0 && s_rxl == '0 && !s_rxv && !s_up && !s_fail && !s_done &&
        !s_half && !s_beat, "R1 std reset", {s_up, s_fail, s_done}, 0);
  endtask

  task automatic adv_bringup(input logic [PW-1:0] fm, input bit expect_ok);
    a_fm = fm; a_td = 1'b1;
    step();
    a_td = 1'b0;
    if (expect_ok) begin
      chk(a_done && a_up && !a_fail, "R5 done with link_up", {a_done, a_up, a_fail}, 3'b110);
      step();
      chk(!a_done && a_up, "R5 done one cycle", {a_done, a_up}, 2'b01);
    end else begin
      chk(a_fail && !a_up && !a_done, "R4 link_fail", {a_fail, a_up, a_done}, 3'b100);
    end
  endtask

  task automatic adv_traffic(input string req);
    logic [PW-1:0] exp_p;
    logic [LW-1:0] exp_l;
    a_txl = {$urandom, $urandom};
    a_rxp = {$urandom, $urandom, $urandom};
    exp_p = '0;
    for (int i = 0; i < LW; i++) begin
      exp_p[pin_of(i)] = a_txl[i];
      exp_l[i] = a_rxp[pin_of(i)];
    end
    step();
    chk(a_txp == exp_p, {req, " tx pins"}, a_txp, exp_p);
    chk(a_rxl == exp_l && a_rxv, {req, " rx lanes"}, a_rxl, exp_l);
  endtask

  task automatic test_adv_clean();
    do_reset();
    for (int g = 0; g < NG; g++) pf[g] = GP;
    adv_bringup('0, 1'b1);
    adv_traffic("R2 identity");
    adv_traffic("R2 identity second word");
  endtask

  task automatic test_adv_repair();
    logic [PW-1:0] fm;
    do_reset();
    fm = '0;
    fm[1*GP+5] = 1'b1;  pf[0] = GP; pf[1] = 5;
    fm[2*GP+GW] = 1'b1; pf[2] = GW;
    fm[3*GP+0] = 1'b1;  pf[3] = 0;
    adv_bringup(fm, 1'b1);
    adv_traffic("R3 repair");
    a_txl = '1;
    step();
    chk(a_txp[1*GP+5] == 1'b0 && a_txp[3*GP] == 1'b0 && a_txp[2*GP+GW] == 1'b0,
        "R3 faulty pins idle", {a_txp[1*GP+5], a_txp[3*GP], a_txp[2*GP+GW]}, 0);
    a_fm = '0; a_fm[0] = 1'b1; a_td = 1'b1;
    step();
    a_td = 1'b0;
    chk(!a_done, "R5 second test_done ignored", a_done, 0);
    adv_traffic("R5 mapping held");
  endtask

  task automatic test_adv_fail();
    logic [PW-1:0] fm;
    do_reset();
    fm = '0; fm[3] = 1'b1; fm[9] = 1'b1;
    adv_bringup(fm, 1'b0);
    a_txl = '1; a_rxp = '1;
    step(); step();
    chk(a_txp == '0 && a_rxl == '0 && !a_rxv && !a_up && a_fail,
        "R4 outputs held quiet", a_txp, 0);
  endtask

  task automatic std_bringup(input logic [SW-1:0] fm);
    s_fm = fm; s_td = 1'b1;
    step();
    s_td = 1'b0;
  endtask

  task automatic test_std_full();
    do_reset();
    std_bringup('0);
    chk(s_done && s_up && !s_half, "R6 full width up", {s_done, s_up, s_half}, 3'b110);
    for (int k = 0; k < 3; k++) begin
      s_txl = 16'($urandom); s_rxp = 16'($urandom);
      step();
      chk(s_txp == s_txl, "R6 tx identity", s_txp, s_txl);
      chk(s_rxl == s_rxp && s_rxv, "R6 rx identity valid", {s_rxv, s_rxl}, {1'b1, s_rxp});
    end
  endtask

  task automatic test_std_half(input bit bad_low);
    logic [SW-1:0] w, r;
    logic [SH-1:0] junk;
    do_reset();
    std_bringup(bad_low ? 16'h0010 : 16'h2000);
    chk(s_up && s_half && !s_fail, "R7 half width selected", {s_up, s_half, s_fail}, 3'b110);
    for (int k = 0; k < 2; k++) begin
      while (s_beat) step();
      w = 16'($urandom); r = 16'($urandom); junk = 8'($urandom);
      s_txl = w;
      s_rxp = bad_low ? {r[SH-1:0], junk} : {junk, r[SH-1:0]};
      step();
      chk(s_txp == (bad_low ? {w[SH-1:0], 8'h00} : {8'h00, w[SH-1:0]}) && s_beat,
          "R7 low beat", s_txp, bad_low ? {w[SH-1:0], 8'h00} : {8'h00, w[SH-1:0]});
      chk(!s_rxv, "R8 no valid after first beat", s_rxv, 0);
      s_rxp = bad_low ? {r[SW-1:SH], ~junk} : {~junk, r[SW-1:SH]};
      step();
      chk(s_txp == (bad_low ? {w[SW-1:SH], 8'h00} : {8'h00, w[SW-1:SH]}) && !s_beat,
          "R7 high beat", s_txp, bad_low ? {w[SW-1:SH], 8'h00} : {8'h00, w[SW-1:SH]});
      chk(s_rxv && s_rxl == r, "R8 assembled word", {s_rxv, s_rxl}, {1'b1, r});
    end
  endtask

  task automatic test_std_fail();
    do_reset();
    std_bringup(16'h0101);
    chk(s_fail && !s_up && !s_half && !s_done, "R9 both halves fail",
        {s_fail, s_up, s_half, s_done}, 4'b1000);
  endtask

  bit finished = 0;

  initial begin
    test_adv_clean();
    test_adv_repair();
    test_adv_fail();
    test_std_full();
    test_std_half(1'b1);
    test_std_half(1'b0);
    test_std_fail();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule